// File: doc/BRIEF.md
# Configurable Set-Associative Tag Directory with LRU Replacement

This block is the tag and valid bookkeeping of a tiny cache that holds four single-word block frames. One elaboration parameter picks how those four frames are organised:

- four sets of one way (direct-mapped);
- two sets of two ways;
- one set of four ways (fully associative).

A caller presents one block number per cycle. One cycle later the block reports hit or miss and the way that now holds the block. On a miss the block also claims a way in the indexed set and counts the miss.

The directory stores no data, follows no write policy and has no memory port. Its purpose is to make visible how conflict misses fall as associativity rises. Three copies with different parameters can be fed the same request stream and their miss counters compared directly.

Top module: `cache_dir`

## Requirements
- R1: With WAYS in {1,2,4} and SETS = 4/WAYS, a request for block number B uses set B mod SETS and tag B >> log2(SETS). For WAYS=4 the tag is all of B.
- R2: A request is a hit when a valid way of its set holds its tag. One cycle after the request, resp_valid is 1 and resp_hit shows the result. resp_way gives the way number within the set, zero-extended: the matching way on a hit, the filled way on a miss.
- R3: On a miss into a set with at least one invalid way, the lowest-numbered invalid way is filled and becomes valid.
- R4: On a miss into a set whose ways are all valid, the least recently used way of that set is replaced.
- R5: Every hit and every fill makes the accessed way the most recently used way of its set. The recency order of other sets is untouched.
- R6: miss_count rises by exactly one for each miss. It is unchanged by hits and by cycles without a request. resp_valid is 0 in cycles that follow no request.
- R7: While clr is 1, at the next clock all ways become invalid, the recency order is reset and miss_count becomes 0. A request presented in the same cycle as clr is ignored: it gives no response and fills nothing.
- R8: Starting from empty, the block sequence 0, 8, 0, 6, 8 ends with miss_count equal to 5 for WAYS=1, 4 for WAYS=2 and 3 for WAYS=4.
- R9: While rst_n is 0, at each clock the block takes the same empty state as after clr, with resp_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the directory and the miss counter |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_blk | input | BLK_W | Block number to look up |
| resp_valid | output | 1 | Result of last cycle's lookup is present |
| resp_hit | output | 1 | 1 for hit, 0 for miss |
| resp_way | output | log2(NBLK) | Way within the set that holds the block |
| miss_count | output | CNT_W | Number of misses since reset or clear |

## Verification
The bench runs all three organisations side by side on one request stream.

- Every pair of blocks from 0 to 15 is swept as the pattern A, B, A. A wrong index or tag split would therefore turn into a hit where a conflict should evict, or the reverse.
- A hit placed between two fills checks that recency is refreshed on hits. A design that tracked only fill order would evict the block that was just used.
- A design that skipped invalid ways, or filled the highest one, would report the wrong way right after a clear.
- A request given together with clr must leave no trace. If it were allowed through, the next lookup of that block would hit.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    // Width of an index able to address n items; never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cd_lookup.sv
// Tag comparison across all ways of one set.
module cd_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    localparam int WAY_W = cache_dir_pkg::idx_w(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    assign hit_o = |match;

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cd_victim.sv
// Chooses the way to fill: lowest invalid way, else the oldest way.
module cd_victim #(
    parameter int WAYS = 2,
    localparam int WAY_W = cache_dir_pkg::idx_w(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][WAY_W-1:0] age_i,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic             any_free;

    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        old_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_i[w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
        end
    end

    assign way_o = any_free ? free_way : old_way;
endmodule

// File: rtl/cd_lru.sv
// Exact recency update: accessed way gets age 0, younger ways age by one.
module cd_lru #(
    parameter int WAYS = 2,
    localparam int WAY_W = cache_dir_pkg::idx_w(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_i,
    input  logic [WAY_W-1:0]           way_i,
    output logic [WAYS-1:0][WAY_W-1:0] age_o
);
    logic [WAY_W-1:0] ref_age;

    assign ref_age = age_i[way_i];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == way_i) begin
                age_o[w] = '0;
            end else if (age_i[w] < ref_age) begin
                age_o[w] = age_i[w] + 1'b1;
            end else begin
                age_o[w] = age_i[w];
            end
        end
    end
endmodule

// File: rtl/cache_dir.sv
module cache_dir #(
    parameter int NBLK  = 4,
    parameter int WAYS  = 2,
    parameter int BLK_W = 8,
    parameter int CNT_W = 16,
    localparam int SETS      = NBLK / WAYS,
    localparam int IDX_BITS  = $clog2(SETS),
    localparam int IDX_W     = cache_dir_pkg::idx_w(SETS),
    localparam int TAG_W     = BLK_W - IDX_BITS,
    localparam int WAY_W     = cache_dir_pkg::idx_w(WAYS),
    localparam int WAY_OUT_W = cache_dir_pkg::idx_w(NBLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 req_valid,
    input  logic [BLK_W-1:0]     req_blk,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [WAY_OUT_W-1:0] resp_way,
    output logic [CNT_W-1:0]     miss_count
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]              valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]   age;
        logic [CNT_W-1:0]                       miss_cnt;
        logic                                   resp_valid;
        logic                                   resp_hit;
        logic [WAY_W-1:0]                       resp_way;
    } dir_t;

    dir_t st_q, st_d;

    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            req_tag;
    logic                        look_hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            vic_way;
    logic [WAY_W-1:0]            use_way;
    logic [WAYS-1:0][WAY_W-1:0]  age_nx;

    assign set_idx = IDX_W'(req_blk % BLK_W'(SETS));
    assign req_tag = TAG_W'(req_blk >> IDX_BITS);

    cd_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_look (
        .valid_i (st_q.valid[set_idx]),
        .tags_i  (st_q.tag[set_idx]),
        .tag_i   (req_tag),
        .hit_o   (look_hit),
        .way_o   (hit_way)
    );

    cd_victim #(.WAYS(WAYS)) u_vic (
        .valid_i (st_q.valid[set_idx]),
        .age_i   (st_q.age[set_idx]),
        .way_o   (vic_way)
    );

    assign use_way = look_hit ? hit_way : vic_way;

    cd_lru #(.WAYS(WAYS)) u_lru (
        .age_i (st_q.age[set_idx]),
        .way_i (use_way),
        .age_o (age_nx)
    );

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        st_d.resp_hit   = 1'b0;
        st_d.resp_way   = '0;
        if (!rst_n || clr) begin
            st_d.valid    = '0;
            st_d.tag      = '0;
            st_d.miss_cnt = '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_d.age[s][w] = WAY_W'(w);
                end
            end
        end else if (req_valid) begin
            st_d.valid[set_idx][use_way] = 1'b1;
            st_d.tag[set_idx][use_way]   = req_tag;
            st_d.age[set_idx]            = age_nx;
            st_d.resp_valid              = 1'b1;
            st_d.resp_hit                = look_hit;
            st_d.resp_way                = use_way;
            if (!look_hit) st_d.miss_cnt = st_q.miss_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign resp_valid = st_q.resp_valid;
    assign resp_hit   = st_q.resp_hit;
    assign resp_way   = WAY_OUT_W'(st_q.resp_way);
    assign miss_count = st_q.miss_cnt;
endmodule

// File: rtl/cache_dir_chk.sv
module cache_dir_chk #(
    parameter int BLK_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             req_valid,
    input logic [BLK_W-1:0] req_blk,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic [CNT_W-1:0] miss_count
);
    AST_MISS_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (miss_count == CNT_W'($past(miss_count) + 1'b1))); // R6

    AST_HIT_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $stable(miss_count)); // R6

    AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!resp_valid && !$past(clr) && $past(rst_n)) |-> $stable(miss_count)); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (miss_count == '0 && !resp_valid)); // R7

    AST_REPEAT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && req_blk == $past(req_blk)
         && !clr && !$past(clr) && $past(rst_n)) |=> resp_hit); // R2
endmodule

bind cache_dir cache_dir_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .miss_count (miss_count)
);

// File: tb/sim_cache_dir.sv
`timescale 1ns/1ps
module sim_cache_dir;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr;
    logic       req_valid;
    logic [7:0] req_blk;
    logic [2:0] rv;
    logic [2:0] rh;
    logic [1:0] rw [3];
    logic [15:0] mc [3];

    always #2 clk = ~clk;

    for (genvar g = 0; g < 3; g++) begin : g_cfg
        cache_dir #(.NBLK(4), .WAYS(1 << g), .BLK_W(8), .CNT_W(16)) u0 (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (clr),
            .req_valid  (req_valid),
            .req_blk    (req_blk),
            .resp_valid (rv[g]),
            .resp_hit   (rh[g]),
            .resp_way   (rw[g]),
            .miss_count (mc[g])
        );
    end

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // Reference model: per frame slot = set*ways + way, with use timestamps.
    bit m_val [3][4];
    int m_blk [3][4];
    int m_tim [3][4];
    int m_miss [3];
    int tnow = 0;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 3; c++) begin
            m_miss[c] = 0;
            for (int k = 0; k < 4; k++) begin
                m_val[c][k] = 0;
                m_blk[c][k] = 0;
                m_tim[c][k] = 0;
            end
        end
    endtask

    task automatic model(int c, int blk, output bit hit, output int way);
        int nw, ns, base, oldest;
        bit found;
        nw = 1 << c;
        ns = 4 / nw;
        base = (blk % ns) * nw;
        hit = 0;
        way = 0;
        for (int w = 0; w < nw; w++)
            if (m_val[c][base + w] && m_blk[c][base + w] == blk) begin
                hit = 1;
                way = w;
            end
        if (!hit) begin
            found = 0;
            for (int w = 0; w < nw; w++)
                if (!found && !m_val[c][base + w]) begin
                    found = 1;
                    way = w;
                end
            if (!found) begin
                oldest = m_tim[c][base];
                for (int w = 0; w < nw; w++)
                    if (m_tim[c][base + w] <= oldest) begin
                        oldest = m_tim[c][base + w];
                        way = w;
                    end
            end
            m_miss[c]++;
        end
        m_val[c][base + way] = 1;
        m_blk[c][base + way] = blk;
        m_tim[c][base + way] = tnow;
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(bit v, int blk, string req);
        bit eh [3];
        int ew [3];
        clr = 1'b0;
        req_valid = v;
        req_blk = blk[7:0];
        tnow++;
        for (int c = 0; c < 3; c++) if (v) model(c, blk, eh[c], ew[c]);
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk(req, $sformatf("cfg%0d resp_valid", c), int'(rv[c]), int'(v));
            if (v) begin
                chk(req, $sformatf("cfg%0d blk%0d hit", c, blk), int'(rh[c]), int'(eh[c]));
                chk(req, $sformatf("cfg%0d blk%0d way", c, blk), int'(rw[c]), ew[c]);
            end
            chk(req, $sformatf("cfg%0d miss_count", c), int'(mc[c]), m_miss[c]);
        end
        req_valid = 1'b0;
    endtask

    task automatic clear(bit v, int blk);
        clr = 1'b1;
        req_valid = v;
        req_blk = blk[7:0];
        @(negedge clk);
        clr = 1'b0;
        req_valid = 1'b0;
        model_clear();
        for (int c = 0; c < 3; c++) begin
            chk("R7", $sformatf("cfg%0d resp_valid after clr", c), int'(rv[c]), 0);
            chk("R7", $sformatf("cfg%0d miss_count after clr", c), int'(mc[c]), 0);
        end
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin : main
        logic [15:0] lf;
        rst_n = 1'b0;
        clr = 1'b0;
        req_valid = 1'b0;
        req_blk = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            chk("R9", $sformatf("cfg%0d resp_valid in reset", c), int'(rv[c]), 0);
            chk("R9", $sformatf("cfg%0d miss_count in reset", c), int'(mc[c]), 0);
        end
        step(1, 0, "R9");

        // R8: reference sequence from empty.
        clear(0, 0);
        step(1, 0, "R8");
        step(1, 8, "R8");
        step(1, 0, "R8");
        step(1, 6, "R8");
        step(1, 8, "R8");
        chk("R8", "direct-mapped misses", int'(mc[0]), 5);
        chk("R8", "2-way misses", int'(mc[1]), 4);
        chk("R8", "fully associative misses", int'(mc[2]), 3);

        // R3: lowest invalid way filled first after a clear.
        clear(0, 0);
        step(1, 0, "R3");
        step(1, 4, "R3");
        step(1, 2, "R3");

        // R5: a hit refreshes recency, so the other way is the victim.
        clear(0, 0);
        step(1, 0, "R5");
        step(1, 4, "R5");
        step(1, 0, "R5");
        step(1, 8, "R5");
        step(1, 0, "R5");
        step(1, 4, "R5");

        // R2: repeated block hits.
        step(1, 4, "R2");
        step(1, 4, "R2");

        // R6: idle cycles leave counter alone and give no response.
        step(0, 9, "R6");
        step(0, 9, "R6");

        // R7: request during clr is ignored.
        clear(0, 0);
        step(1, 5, "R7");
        clear(1, 5);
        step(1, 5, "R7");

        // R1: all pairs A,B,A over blocks 0..15.
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                clear(0, 0);
                step(1, a, "R1");
                step(1, b, "R1");
                step(1, a, "R1");
            end

        // R4: long pseudo-random stream forcing evictions.
        clear(0, 0);
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i < 2000) step(lf[15:14] != 2'b00, int'(lf[3:0]), "R4");
            else          step(lf[15:14] != 2'b00, int'(lf[7:0]), "R4");
        end

        done = 1;
        report();
    end
endmodule